// File: doc/BRIEF.md
# Nonvolatile Configuration Save/Restore Controller

This block sits beside an I2C slave engine and a one-time-programmable (OTP) store. It holds the device's configuration register file and copies it in either direction between the registers and the OTP. Software asks for a copy by writing a command byte to a fixed register: one bit asks for a save (registers into OTP) and another asks for a restore (OTP into registers). The command is only armed by the write. The copy starts when the bus master issues STOP, so a complete request is just the write address byte followed by the command byte.

While a copy runs, the block tells the slave engine to stop acknowledging, and the device stays silent on the bus. Acknowledges come back only when the copy has finished. Leaving reset starts a restore on its own, so the first acknowledge after power-up comes only once the register file has been reloaded. The block also supplies the 7-bit slave address to the engine. It picks one of two values from a configuration bit held in the register file.

The OTP is reached through a simple word port that moves one byte per request. A request is held until the store answers with a one-cycle done pulse. The register that holds the command is never copied, in either direction.

Top module: `nv_save_restore`

## Requirements
- R1: When reset is released, a restore starts at once: `ackEnable` is 0 and the busy bit is set on the first cycle after release. When the restore completes, every register except address 114 holds the OTP byte of the same address.
- R2: `slaveAddr` is 7'h6A while bit 0 of register 0 is 0, and 7'h69 while that bit is 1.
- R3: A save copies every register except address 114 into the OTP byte of the same address.
- R4: A restore copies every OTP byte except address 114 into the register of the same address.
- R5: Writing register 114 only arms the command. Bit 3 arms a save and bit 0 arms a restore. No copy starts until a `busStop` pulse arrives, and until then register 114 reads back the armed bits.
- R6: `ackEnable` is 0 exactly while a copy runs. Reading register 114 returns the busy flag in bit 7, the armed save in bit 3 and the armed restore in bit 0; all other bits read 0.
- R7: If save and restore are armed together, the STOP starts a restore and the save bit is cleared when the restore starts. The OTP is left unchanged.
- R8: When a copy completes, both command bits read 0.
- R9: Register writes that arrive while a copy runs are ignored. This includes writes to register 114.
- R10: Each OTP request holds `otpReq` and `otpAddr` steady until `otpDone`. Address 114 is never requested, and OTP byte 114 is never written.
- R11: A `busStop` pulse with no command armed starts nothing, and `ackEnable` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; its release starts the automatic restore |
| regWrEn | input | 1 | Register write strobe from the slave engine |
| regWrAddr | input | 7 | Register write address |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 7 | Register read address |
| regRdData | output | 8 | Register read data (combinational) |
| busStop | input | 1 | One-cycle pulse when STOP is seen on the bus |
| ackEnable | output | 1 | 1 when the slave engine may acknowledge |
| slaveAddr | output | 7 | 7-bit slave address currently in force |
| otpReq | output | 1 | OTP access request, held until done |
| otpWe | output | 1 | 1 for an OTP write (save), 0 for a read (restore) |
| otpAddr | output | 7 | OTP byte address |
| otpWData | output | 8 | Byte to write into the OTP |
| otpRData | input | 8 | Byte read from the OTP, valid with `otpDone` |
| otpDone | input | 1 | One-cycle completion pulse from the OTP |

## Verification
Two things can happen in the same cycle: the save and restore requests, when both are armed in one command byte and then released by a single STOP. The bench writes that byte directly and reads register 114 on the first cycle after STOP. It expects busy with only the restore bit left. It then judges the result at the ports: the registers must equal the OTP contents, and the bench's own model of the OTP must be byte-for-byte untouched. Random rounds of register scribbles and random save or restore choices, each with a write attempted mid-copy, are checked against mirror arrays that the bench keeps.

// File: rtl/nvPkg.sv
package nvPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadByte;  // capture OTP byte into the register at the copy index
    logic xferBusy;  // a copy is running: block host writes
  } dpCtl_t;
endpackage

// File: rtl/nvCtrl.sv
module nvCtrl
  import nvPkg::*;
#(
  parameter int N_REGS      = 128,
  parameter int CMD_ADDR    = 114,
  parameter int SAVE_BIT    = 3,
  parameter int RESTORE_BIT = 0,
  parameter int IDX_W       = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrAddr,
  input  logic [7:0]       regWrData,
  input  logic             busStop,
  input  logic             otpDone,
  output logic             otpReq,
  output logic             otpWe,
  output logic [IDX_W-1:0] xferIdx,
  output logic             pendSave,
  output logic             pendRestore,
  output dpCtl_t           dpCtl
);
  localparam int FIRST_IDX = (CMD_ADDR == 0) ? 1 : 0;
  localparam int LAST_IDX  = (CMD_ADDR == N_REGS - 1) ? N_REGS - 2 : N_REGS - 1;

  xferState_t state;
  logic       curRestore;
  logic       cmdWr;
  logic       startXfer;
  logic [IDX_W-1:0] nextIdx;

  assign cmdWr     = regWrEn && (regWrAddr == IDX_W'(CMD_ADDR));
  assign startXfer = busStop && (pendSave || pendRestore);

  // advance past the command register
  always_comb begin
    nextIdx = xferIdx + 1'b1;
    if (nextIdx == IDX_W'(CMD_ADDR)) nextIdx = nextIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_REQ;       // automatic restore out of reset
      curRestore  <= 1'b1;
      xferIdx     <= IDX_W'(FIRST_IDX);
      pendSave    <= 1'b0;
      pendRestore <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startXfer) begin
            state      <= ST_REQ;
            curRestore <= pendRestore;
            xferIdx    <= IDX_W'(FIRST_IDX);
            if (pendRestore) pendSave <= 1'b0;
          end else if (cmdWr) begin
            pendSave    <= regWrData[SAVE_BIT];
            pendRestore <= regWrData[RESTORE_BIT];
          end
        end
        ST_REQ: begin
          if (otpDone) begin
            if (xferIdx == IDX_W'(LAST_IDX)) begin
              state       <= ST_IDLE;
              pendSave    <= 1'b0;
              pendRestore <= 1'b0;
            end else begin
              state   <= ST_GAP;
              xferIdx <= nextIdx;
            end
          end
        end
        ST_GAP:  state <= ST_REQ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    otpReq         = (state == ST_REQ);
    otpWe          = otpReq && !curRestore;
    dpCtl.loadByte = otpReq && otpDone && curRestore;
    dpCtl.xferBusy = (state != ST_IDLE);
  end

  // a copy may only begin on the cycle after STOP
  p_start_after_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dpCtl.xferBusy) |-> $past(busStop));

  // restore wins and drops the save request
  p_restore_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dpCtl.xferBusy) && curRestore) |-> !pendSave);

  // command bits are clear once a copy ends
  p_cmd_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dpCtl.xferBusy) |-> (!pendSave && !pendRestore));

  // request and address held until the store answers
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (otpReq && !otpDone) |=> (otpReq && $stable(xferIdx)));

  // the command register is never part of a copy
  p_skip_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    otpReq |-> (xferIdx != IDX_W'(CMD_ADDR)));

  // STOP without an armed command leaves the block idle
  p_idle_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && busStop && !pendSave && !pendRestore) |=> (state == ST_IDLE));
endmodule

// File: rtl/nvData.sv
module nvData
  import nvPkg::*;
#(
  parameter int N_REGS       = 128,
  parameter int CMD_ADDR     = 114,
  parameter int SAVE_BIT     = 3,
  parameter int RESTORE_BIT  = 0,
  parameter int BUSY_BIT     = 7,
  parameter int ADDR_SEL_REG = 0,
  parameter int ADDR_SEL_BIT = 0,
  parameter logic [6:0] ADDR_PRIMARY = 7'h6A,
  parameter logic [6:0] ADDR_ALT     = 7'h69,
  parameter int IDX_W        = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic [IDX_W-1:0] xferIdx,
  input  logic             pendSave,
  input  logic             pendRestore,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrAddr,
  input  logic [7:0]       regWrData,
  input  logic [IDX_W-1:0] regRdAddr,
  output logic [7:0]       regRdData,
  input  logic [7:0]       otpRData,
  output logic [7:0]       otpWData,
  output logic [6:0]       slaveAddr
);
  logic [N_REGS-1:0][7:0] regFile;
  logic [7:0] cmdView;
  logic       hostWr;

  assign hostWr = regWrEn && !dpCtl.xferBusy && (regWrAddr != IDX_W'(CMD_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (dpCtl.loadByte) begin
      regFile[xferIdx] <= otpRData;
    end else if (hostWr) begin
      regFile[regWrAddr] <= regWrData;
    end
  end

  always_comb begin
    for (int b = 0; b < 8; b++) begin
      cmdView[b] = (b == BUSY_BIT)    ? dpCtl.xferBusy :
                   (b == SAVE_BIT)    ? pendSave :
                   (b == RESTORE_BIT) ? pendRestore : 1'b0;
    end
  end

  assign regRdData = (regRdAddr == IDX_W'(CMD_ADDR)) ? cmdView : regFile[regRdAddr];
  assign otpWData  = regFile[xferIdx];
  assign slaveAddr = regFile[ADDR_SEL_REG][ADDR_SEL_BIT] ? ADDR_ALT : ADDR_PRIMARY;

  // host writes never land while a copy runs
  p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.xferBusy && !dpCtl.loadByte) |=> $stable(regFile));

  // a restored byte lands at the copy index
  p_load_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.loadByte |=> (regFile[$past(xferIdx)] == $past(otpRData)));
endmodule

// File: rtl/nv_save_restore.sv
module nv_save_restore
  import nvPkg::*;
#(
  parameter int N_REGS = 128,
  parameter int CMD_ADDR = 114,
  parameter int IDX_W = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrAddr,
  input  logic [7:0]       regWrData,
  input  logic [IDX_W-1:0] regRdAddr,
  output logic [7:0]       regRdData,
  input  logic             busStop,
  output logic             ackEnable,
  output logic [6:0]       slaveAddr,
  output logic             otpReq,
  output logic             otpWe,
  output logic [IDX_W-1:0] otpAddr,
  output logic [7:0]       otpWData,
  input  logic [7:0]       otpRData,
  input  logic             otpDone
);
  dpCtl_t           dpCtl;
  logic [IDX_W-1:0] xferIdx;
  logic             pendSave;
  logic             pendRestore;

  nvCtrl #(.N_REGS(N_REGS), .CMD_ADDR(CMD_ADDR), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .busStop(busStop), .otpDone(otpDone),
    .otpReq(otpReq), .otpWe(otpWe), .xferIdx(xferIdx),
    .pendSave(pendSave), .pendRestore(pendRestore), .dpCtl(dpCtl)
  );

  nvData #(.N_REGS(N_REGS), .CMD_ADDR(CMD_ADDR), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .xferIdx(xferIdx),
    .pendSave(pendSave), .pendRestore(pendRestore),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .otpRData(otpRData), .otpWData(otpWData), .slaveAddr(slaveAddr)
  );

  assign otpAddr   = xferIdx;
  assign ackEnable = !dpCtl.xferBusy;

  // the bus stays silent exactly while a copy runs
  p_silent_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    otpReq |-> !ackEnable);
endmodule

// File: tb/sim_nv_save_restore.sv
module sim_nv_save_restore;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;
  localparam int CMD = 114;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [6:0] regWrAddr = '0;
  logic [7:0] regWrData = '0;
  logic [6:0] regRdAddr = '0;
  logic [7:0] regRdData;
  logic       busStop = 1'b0;
  logic       ackEnable;
  logic [6:0] slaveAddr;
  logic       otpReq, otpWe;
  logic [6:0] otpAddr;
  logic [7:0] otpWData;
  logic [7:0] otpRData = '0;
  logic       otpDone = 1'b0;
  logic       memInit = 1'b0;

  nv_save_restore u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .busStop(busStop), .ackEnable(ackEnable), .slaveAddr(slaveAddr),
    .otpReq(otpReq), .otpWe(otpWe), .otpAddr(otpAddr), .otpWData(otpWData),
    .otpRData(otpRData), .otpDone(otpDone)
  );

  function automatic logic [7:0] fillByte(int k);
    return 8'((k * 29 + 7) ^ 8'hA5);
  endfunction

  function automatic logic [6:0] expSlave(logic [7:0] reg0);
    return reg0[0] ? 7'h69 : 7'h6A;
  endfunction

  // OTP model: one byte per request, done pulse after 4 clocks
  logic [7:0] otpMem [N];
  logic [1:0] lat = '0;
  always_ff @(posedge clk) begin
    otpDone <= 1'b0;
    if (memInit) begin
      for (int k = 0; k < N; k++) otpMem[k] <= fillByte(k);
      lat <= '0;
    end else if (otpReq && !otpDone) begin
      if (lat == 2'd3) begin
        otpDone  <= 1'b1;
        lat      <= '0;
        otpRData <= otpMem[otpAddr];
        if (otpWe) otpMem[otpAddr] <= otpWData;
      end else begin
        lat <= lat + 1'b1;
      end
    end
  end

  logic [7:0] expOtp [N];
  logic [7:0] expReg [N];
  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  task automatic writeReg(int a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = 7'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(int a, output logic [7:0] v);
    regRdAddr = 7'(a);
    #1 v = regRdData;
  endtask

  task automatic stopPulse();
    @(negedge clk); busStop = 1'b1;
    @(negedge clk); busStop = 1'b0;
  endtask

  task automatic waitIdle(string req);
    int n = 0;
    while (!ackEnable && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(ackEnable, req, ackEnable, 1);
  endtask

  task automatic checkRegs(string req);
    int bad = 0; int fa = 0; logic [7:0] fv = '0; logic [7:0] v;
    for (int k = 0; k < N; k++) begin
      if (k == CMD) continue;
      readReg(k, v);
      if (v !== expReg[k]) begin
        if (bad == 0) begin fa = k; fv = v; end
        bad++;
      end
    end
    chk(bad == 0, req, fv, expReg[fa]);
  endtask

  task automatic checkOtp(string req);
    int bad = 0; int fa = 0;
    for (int k = 0; k < N; k++)
      if (otpMem[k] !== expOtp[k]) begin
        if (bad == 0) fa = k;
        bad++;
      end
    chk(bad == 0, req, otpMem[fa], expOtp[fa]);
  endtask

  task automatic applySave();
    for (int k = 0; k < N; k++) if (k != CMD) expOtp[k] = expReg[k];
  endtask

  task automatic applyRestore();
    for (int k = 0; k < N; k++) if (k != CMD) expReg[k] = expOtp[k];
  endtask

  task automatic scribble(int cnt);
    for (int i = 0; i < cnt; i++) begin
      int a = int'($urandom % N);
      logic [7:0] d = 8'($urandom);
      if (a == CMD) continue;
      writeReg(a, d);
      expReg[a] = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++; nChk++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5A17C0DE));
    for (int k = 0; k < N; k++) begin expOtp[k] = fillByte(k); expReg[k] = 8'h00; end

    // reset and automatic restore
    memInit = 1'b1;
    repeat (3) @(negedge clk);
    memInit = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(ackEnable == 1'b0, "R1 silent after reset", ackEnable, 0);
    readReg(CMD, v);
    chk(v == 8'h80, "R6 busy bit during auto restore", v, 8'h80);
    waitIdle("R1 auto restore completes");
    applyRestore();
    checkRegs("R1 registers hold OTP after reset");
    readReg(CMD, v);
    chk(v == 8'h00, "R8 command idle after auto restore", v, 0);
    chk(slaveAddr == expSlave(expReg[0]), "R2 address from restored bit", slaveAddr, expSlave(expReg[0]));

    // address select directed
    writeReg(0, 8'h01); expReg[0] = 8'h01;
    #1 chk(slaveAddr == 7'h69, "R2 alternate address", slaveAddr, 7'h69);
    writeReg(0, 8'hFE); expReg[0] = 8'hFE;
    #1 chk(slaveAddr == 7'h6A, "R2 primary address", slaveAddr, 7'h6A);

    // stop with nothing armed
    stopPulse();
    chk(ackEnable == 1'b1, "R11 empty STOP starts nothing", ackEnable, 1);
    repeat (5) @(negedge clk);
    chk(ackEnable == 1'b1, "R11 still idle", ackEnable, 1);

    // save, armed but waiting for STOP
    scribble(30);
    writeReg(CMD, 8'h08);
    repeat (20) @(negedge clk);
    chk(ackEnable == 1'b1, "R5 no copy before STOP", ackEnable, 1);
    readReg(CMD, v);
    chk(v == 8'h08, "R5 armed save readable", v, 8'h08);
    checkOtp("R5 OTP untouched before STOP");
    stopPulse();
    chk(ackEnable == 1'b0, "R6 silent during save", ackEnable, 0);
    readReg(CMD, v);
    chk(v == 8'h88, "R6 busy plus save bit", v, 8'h88);
    writeReg(5, ~expReg[5]);
    writeReg(CMD, 8'h01);
    waitIdle("R3 save completes");
    applySave();
    checkRegs("R9 write during save ignored");
    checkOtp("R3 OTP holds saved registers, R10 byte 114 untouched");
    readReg(CMD, v);
    chk(v == 8'h00, "R8 save bit cleared, R9 command write ignored", v, 0);

    // restore
    scribble(40);
    writeReg(CMD, 8'h01);
    stopPulse();
    chk(ackEnable == 1'b0, "R6 silent during restore", ackEnable, 0);
    waitIdle("R4 restore completes");
    applyRestore();
    checkRegs("R4 registers equal OTP");
    readReg(CMD, v);
    chk(v == 8'h00, "R8 restore bit cleared", v, 0);

    // both armed together
    scribble(20);
    writeReg(CMD, 8'h09);
    readReg(CMD, v);
    chk(v == 8'h09, "R5 both bits armed", v, 8'h09);
    stopPulse();
    readReg(CMD, v);
    chk(v == 8'h81, "R7 restore wins, save cleared", v, 8'h81);
    waitIdle("R7 copy completes");
    applyRestore();
    checkRegs("R7 registers restored");
    checkOtp("R7 OTP unchanged");

    // random rounds
    for (int r = 0; r < 6; r++) begin
      bit doSave;
      int a;
      scribble(15);
      doSave = bit'($urandom % 2);
      writeReg(CMD, doSave ? 8'h08 : 8'h01);
      stopPulse();
      a = int'($urandom % N);
      if (a != CMD) writeReg(a, ~expReg[a]);
      waitIdle("R6 random round ends");
      if (doSave) applySave(); else applyRestore();
      checkRegs(doSave ? "R3 R9 random save regs" : "R4 R9 random restore regs");
      checkOtp(doSave ? "R3 random save OTP" : "R10 random restore OTP");
      chk(slaveAddr == expSlave(expReg[0]), "R2 random address", slaveAddr, expSlave(expReg[0]));
    end

    // second reset: registers come back from the last saved OTP
    scribble(25);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(ackEnable == 1'b0, "R1 silent after second reset", ackEnable, 0);
    waitIdle("R1 second auto restore");
    applyRestore();
    checkRegs("R1 registers reload after reset");
    checkOtp("R10 OTP intact across reset");

    summary();
  end
endmodule